// File: doc/BRIEF.md
# Built-in Logic Block Observer Register

This block is a bank of `WIDTH` flip-flops that a two-bit mode input reconfigures into one of four structures: a plain parallel-load register between two pieces of logic, a serial scan chain, a pseudo-random test pattern generator, or a multiple-input signature compactor. The same state drives the parallel output in every mode. Upstream logic feeds the parallel data input, and downstream logic reads the parallel output.

The generator and the compactor use one shared feedback network. It is an internal-XOR (modular) linear feedback shift register whose taps come from a primitive polynomial fixed at elaboration. The two modes differ only in whether the parallel input word is XORed into the next state. A synchronous seed load sets the starting state. The usual starts are all zeros for signature collection and a non-zero value for pattern generation. A clock enable freezes the register in every mode.

A test controller outside the block sequences the epochs. It loads a seed, runs the generator or the compactor for a chosen number of cycles, then shifts the result out through the scan path or reads it in parallel.

Top module: `bilbo_reg`

## Requirements
- R1: An active-low asynchronous reset clears every state bit to 0 at once, so `q` and `scan_out` read 0.
- R2: While `ce` is 0 the state holds its value in every mode, and `seed_ld` has no effect.
- R3: With `ce`=1, `seed_ld`=0 and `mode`=2'b00, the next state equals `pdata_in`.
- R4: With `mode`=2'b01 the state shifts toward the high index: bit 0 takes `scan_in`, bit i takes old bit i-1, and `scan_out` always shows bit WIDTH-1.
- R5: With `mode`=2'b10 and a non-zero state, the next state is X0'=X[W-1] and Xi'=X[i-1] XOR (h_i AND X[W-1]) for i≥1. The default taps for WIDTH=8 are x^8+x^6+x^5+x^4+1, so h4, h5 and h6 are 1 and the other coefficients are 0.
- R6: Started from any non-zero state, generator mode returns to that state after exactly 2^WIDTH−1 steps (255 for WIDTH=8) and never reaches 0.
- R7: Generator mode never produces the all-zero state. A zero state steps to 1 (only bit 0 set), and a zero seed loaded in generator mode loads 1.
- R8: With `mode`=2'b11 and `seed_ld`=0, the next state is the R5 step of the current state XORed bitwise with `pdata_in`.
- R9: With `ce`=1 and `seed_ld`=1, `seed` is loaded in any mode and takes priority over the mode's own function. The only exception is the zero-seed case of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; the state holds when low |
| mode | input | 2 | 00 load, 01 scan, 10 generate, 11 compact |
| seed_ld | input | 1 | Synchronous seed load |
| seed | input | WIDTH | Seed value |
| pdata_in | input | WIDTH | Parallel data from upstream logic |
| scan_in | input | 1 | Serial scan input into bit 0 |
| q | output | WIDTH | Parallel state output |
| scan_out | output | 1 | Serial scan output from bit WIDTH-1 |

## Verification
The whole state is visible on `q` after every enabled edge. A wrong tap, a swapped shift direction or a missing data XOR therefore shows up as a mismatch one cycle after the faulty step. A tap error that leaves the first few states correct still changes the state by the first cycle in which the top bit is 1. A feedback that is not primitive has no single-step signature. It shows only as an early or late return to the seed during the full 255-step run, which is why that run ends on a check of the seed value. The zero lock-up guard is visible one cycle after a zero state meets generator mode.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

   typedef enum logic [1:0] {
      BM_LOAD = 2'b00,
      BM_SCAN = 2'b01,
      BM_GEN  = 2'b10,
      BM_SIG  = 2'b11
   } bilbo_mode_e;

   localparam int unsigned MIN_WIDTH = 3;
   localparam int unsigned MAX_WIDTH = 16;

   // Coefficient masks of primitive polynomials, x^n term omitted.
   // Bit i holds h_i; bit 0 is the constant term and is always set.
   function automatic logic [MAX_WIDTH-1:0] prim_taps(input int unsigned width);
      logic [MAX_WIDTH-1:0] m;
      case (width)
         3:       m = 16'h0003;
         4:       m = 16'h0003;
         5:       m = 16'h0005;
         6:       m = 16'h0003;
         7:       m = 16'h0003;
         8:       m = 16'h0071;
         9:       m = 16'h0011;
         10:      m = 16'h0009;
         11:      m = 16'h0005;
         12:      m = 16'h0053;
         13:      m = 16'h001B;
         14:      m = 16'h0443;
         15:      m = 16'h0003;
         16:      m = 16'h100B;
         default: m = 16'h0001;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bilbo_feedback.sv
// Modular (internal-XOR) step: multiply the state polynomial by x
// modulo the characteristic polynomial given by HMASK.
module bilbo_feedback #(
   parameter int unsigned WIDTH = 8,
   parameter logic [WIDTH-1:0] HMASK = '0
) (
   input  logic [WIDTH-1:0] x,
   output logic [WIDTH-1:0] y
);

   localparam int unsigned TOP = WIDTH - 1;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign y[i] = x[TOP];
         end else if (HMASK[i]) begin : g_tap
            assign y[i] = x[i-1] ^ x[TOP];
         end else begin : g_wire
            assign y[i] = x[i-1];
         end
      end
   endgenerate

endmodule

// File: rtl/bilbo_next_sel.sv
module bilbo_next_sel
   import bilbo_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [1:0]       mode,
   input  logic             seed_ld,
   input  logic [WIDTH-1:0] seed,
   input  logic [WIDTH-1:0] pdata_in,
   input  logic             scan_in,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] stepped,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] ZERO = '0;

   bilbo_mode_e m;
   assign m = bilbo_mode_e'(mode);

   always_comb begin
      nxt = cur;
      if (seed_ld) begin
         if (m == BM_GEN && seed == ZERO) nxt = ONE;
         else                             nxt = seed;
      end else begin
         unique case (m)
            BM_LOAD: nxt = pdata_in;
            BM_SCAN: nxt = {cur[WIDTH-2:0], scan_in};
            BM_GEN:  nxt = (cur == ZERO) ? ONE : stepped;
            BM_SIG:  nxt = stepped ^ pdata_in;
            default: nxt = cur;
         endcase
      end
   end

endmodule

// File: rtl/bilbo_state_reg.sv
module bilbo_state_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= d;
   end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
   import bilbo_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter logic [15:0] TAP_MASK = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [1:0]       mode,
   input  logic             seed_ld,
   input  logic [WIDTH-1:0] seed,
   input  logic [WIDTH-1:0] pdata_in,
   input  logic             scan_in,
   output logic [WIDTH-1:0] q,
   output logic             scan_out
);

   localparam logic [15:0] TABLE_MASK = prim_taps(WIDTH);
   localparam logic [15:0] SEL_MASK   = (TAP_MASK == 16'h0000) ? TABLE_MASK : TAP_MASK;
   localparam logic [WIDTH-1:0] HMASK = SEL_MASK[WIDTH-1:0];

   generate
      if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("bilbo_reg: WIDTH must lie between 3 and 16");
      end
      if (!SEL_MASK[0]) begin : g_bad_taps
         $error("bilbo_reg: constant term of the polynomial must be set");
      end
   endgenerate

   logic [WIDTH-1:0] state;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] nxt;

   bilbo_feedback #(.WIDTH(WIDTH), .HMASK(HMASK)) u_fb (
      .x (state),
      .y (stepped)
   );

   bilbo_next_sel #(.WIDTH(WIDTH)) u_sel (
      .mode     (mode),
      .seed_ld  (seed_ld),
      .seed     (seed),
      .pdata_in (pdata_in),
      .scan_in  (scan_in),
      .cur      (state),
      .stepped  (stepped),
      .nxt      (nxt)
   );

   bilbo_state_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .d     (nxt),
      .q     (state)
   );

   assign q        = state;
   assign scan_out = state[WIDTH-1];

endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce,
   input logic [1:0]       mode,
   input logic             seed_ld,
   input logic [WIDTH-1:0] seed,
   input logic [WIDTH-1:0] pdata_in,
   input logic             scan_in,
   input logic [WIDTH-1:0] q,
   input logic             scan_out
);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(q));

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !seed_ld && mode == 2'b00) |=> q == $past(pdata_in));

   p_scan_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !seed_ld && mode == 2'b01) |=>
         (q[0] == $past(scan_in)) && (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

   p_scan_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !seed_ld && mode == 2'b01) |=> scan_out == $past(q[WIDTH-2]));

   p_gen_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && mode == 2'b10) |=> q != '0);

   p_sig_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !seed_ld && mode == 2'b11) |=> q[0] == ($past(q[WIDTH-1]) ^ $past(pdata_in[0])));

   p_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && seed_ld && mode != 2'b10) |=> q == $past(seed));

endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce       (ce),
   .mode     (mode),
   .seed_ld  (seed_ld),
   .seed     (seed),
   .pdata_in (pdata_in),
   .scan_in  (scan_in),
   .q        (q),
   .scan_out (scan_out)
);

// File: tb/tb_bilbo_reg.sv
module tb_bilbo_reg;

   localparam int W = 8;
   localparam time CLK_PERIOD = 10;
   localparam logic [W-1:0] H = 8'h71; // R5: h0,h4,h5,h6

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ce = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         seed_ld = 1'b0;
   logic [W-1:0] seed = '0;
   logic [W-1:0] pdata_in = '0;
   logic         scan_in = 1'b0;
   logic [W-1:0] q;
   logic         scan_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;
   item_t sb[$];
   logic [W-1:0] mdl = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bilbo_reg dut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .mode(mode), .seed_ld(seed_ld),
      .seed(seed), .pdata_in(pdata_in), .scan_in(scan_in),
      .q(q), .scan_out(scan_out)
   );

   function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] x, input logic [W-1:0] d);
      logic [W-1:0] y;
      y[0] = x[W-1] ^ d[0];
      for (int i = 1; i < W; i++) y[i] = x[i-1] ^ (H[i] & x[W-1]) ^ d[i];
      return y;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic c, input logic [1:0] m, input logic sl,
                        input logic [W-1:0] sd, input logic [W-1:0] pd,
                        input logic si, input logic [W-1:0] exp, input string tag);
      @(negedge clk);
      ce = c; mode = m; seed_ld = sl; seed = sd; pdata_in = pd; scan_in = si;
      sb.push_back('{exp: exp, tag: tag});
      mdl = exp;
   endtask

   // Monitor: compares one scoreboard entry after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, q, it.exp);
            check({it.tag, " scan_out"}, {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, it.exp[W-1]});
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] nx;
      logic [W-1:0] d;
      #(CLK_PERIOD*2 + 2);
      check("R1 reset q", q, '0);
      check("R1 reset scan_out", {{(W-1){1'b0}}, scan_out}, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 parallel load
      drive(1, 2'b00, 0, '0, 8'hA5, 0, 8'hA5, "R3");
      drive(1, 2'b00, 0, '0, 8'h3C, 0, 8'h3C, "R3");

      // R2 hold with ce low in every mode, seed_ld ignored
      drive(0, 2'b00, 0, '0, 8'hFF, 1, mdl, "R2");
      drive(0, 2'b01, 0, '0, 8'hFF, 1, mdl, "R2");
      drive(0, 2'b10, 0, '0, 8'hFF, 1, mdl, "R2");
      drive(0, 2'b11, 0, '0, 8'hFF, 1, mdl, "R2");
      drive(0, 2'b00, 1, 8'h77, 8'hFF, 1, mdl, "R2");

      // R4 scan shift
      drive(1, 2'b01, 0, '0, 8'h00, 1, {mdl[W-2:0], 1'b1}, "R4");
      drive(1, 2'b01, 0, '0, 8'h00, 0, {mdl[W-2:0], 1'b0}, "R4");
      drive(1, 2'b01, 0, '0, 8'h00, 1, {mdl[W-2:0], 1'b1}, "R4");
      drive(1, 2'b01, 0, '0, 8'h00, 1, {mdl[W-2:0], 1'b1}, "R4");

      // R9 seed priority in load mode
      drive(1, 2'b00, 1, 8'h5B, 8'hC3, 0, 8'h5B, "R9");

      // R5 generator steps from arbitrary state
      for (int k = 0; k < 20; k++) drive(1, 2'b10, 0, '0, 8'hFF, 0, lfsr_step(mdl, '0), "R5");

      // R6 full period from seed 1
      drive(1, 2'b10, 1, 8'h01, 8'h00, 0, 8'h01, "R9");
      for (int k = 1; k <= 255; k++) begin
         nx = lfsr_step(mdl, '0);
         if (k == 255) drive(1, 2'b10, 0, '0, 8'h00, 0, 8'h01, "R6");
         else if (nx == '0) drive(1, 2'b10, 0, '0, 8'h00, 0, 8'hFF, "R6 zero reached");
         else drive(1, 2'b10, 0, '0, 8'h00, 0, nx, "R5");
      end

      // R7 zero lock-up guard
      drive(1, 2'b00, 0, '0, 8'h00, 0, 8'h00, "R3");
      drive(1, 2'b10, 0, '0, 8'h00, 0, 8'h01, "R7");
      drive(1, 2'b10, 1, 8'h00, 8'h00, 0, 8'h01, "R7");

      // R8 signature compaction from zero seed
      drive(1, 2'b11, 1, 8'h00, 8'hEE, 0, 8'h00, "R9");
      for (int k = 0; k < 12; k++) begin
         d = 8'(k * 37 + 11) ^ 8'h96;
         drive(1, 2'b11, 0, '0, d, 0, lfsr_step(mdl, d), "R8");
      end
      drive(1, 2'b11, 0, '0, 8'h00, 0, lfsr_step(mdl, 8'h00), "R8");

      // R1 asynchronous reset mid-run
      @(negedge clk);
      ce = 0;
      #2;
      rst_n = 1'b0;
      #1;
      check("R1 async q", q, '0);
      check("R1 async scan_out", {{(W-1){1'b0}}, scan_out}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule